// File: doc/BRIEF.md
# Byte-Lane DMA FIFO with Parity

This block buffers DMA data in four separate byte lanes. Each lane is a 16-entry first-in first-out store, and every entry holds a data byte together with one parity bit. In normal use, a 32-bit word stream enters and leaves the block. Byte i of each word goes to lane i, and all four lanes move in the same cycle. The parity bit for each byte is generated on the way in.

A second port, shaped like a register interface, lets diagnostic software work on one lane at a time. Software picks a lane with a select field. It can then push a byte whose parity bit it supplies itself, or pop a byte and read back both the byte and the parity stored with it. Per-lane empty and full masks, a derived "all empty" flag and a sticky overflow flag report the fill state. A soft-reset input empties every lane in one cycle.

Both word ports use valid/ready handshakes. A word is accepted only in a cycle where `in_valid` and `in_ready` are both high. A word is consumed only in a cycle where `out_valid` and `out_ready` are both high. `in_ready` never depends on `in_valid`, and `out_valid` never depends on `out_ready`. A test strobe or a soft reset in the current cycle holds both word ports off for that cycle.

Top module: `lane_dma_fifo`

## Requirements
- R1: After `rst_n` is released, the outputs read as follows: `empty_mask` = 4'hF, `full_mask` = 4'h0, `fifo_empty` = 1, `overflow` = 0, `in_ready` = 1, `out_valid` = 0, `tst_rd_byte` = 8'h00 and `tst_rd_par` = 0.
- R2: When `tst_push` is high at a clock edge, `tst_byte` is stored in the lane numbered by `tst_lane` (0 to 3). The stored parity bit is exactly `tst_par`; no parity is computed.
- R3: When `tst_pop` is high at a clock edge and the selected lane is not empty, the oldest entry of that lane is removed. From the next cycle, that entry's byte appears on `tst_rd_byte` and its stored parity on `tst_rd_par`. Each lane returns its entries in the order they were written.
- R4: The lanes are independent. Bit k of `empty_mask` is 1 exactly when lane k holds no entries, and a test operation on one lane never changes another lane.
- R5: Bit k of `full_mask` is 1 exactly when lane k holds 16 entries.
- R6: A test push to a full lane is ignored, and its contents stay unchanged. The push sets `overflow`, which then stays high until reset or soft reset.
- R7: A test pop from an empty lane sets `tst_rd_byte` to 8'h00 and `tst_rd_par` to 0, and leaves the fill state unchanged.
- R8: `in_ready` is high exactly when every lane has room and none of `tst_push`, `tst_pop` or `soft_rst` is high. An accepted word places byte i (bits 8i+7 to 8i) in lane i. Each byte's parity is generated as odd parity: the byte plus its parity bit hold an odd number of ones.
- R9: `out_valid` is high exactly when every lane holds data and none of `tst_push`, `tst_pop` or `soft_rst` is high. `out_data` byte i is the oldest byte of lane i, and `out_par[i]` is that byte's stored parity.
- R10: `fifo_empty` is 1 exactly when all four lanes are empty.
- R11: A clock edge with `soft_rst` high empties every lane and clears `overflow`, `tst_rd_byte` and `tst_rd_par`. Any push or pop in that same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of all lanes and flags |
| in_valid | input | 1 | Word offered on `in_data` |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_data | input | 32 | Word to store, byte i to lane i |
| out_valid | output | 1 | A full word is available on `out_data` |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_data | output | 32 | Oldest byte of each lane |
| out_par | output | 4 | Stored parity of each `out_data` byte |
| tst_lane | input | 2 | Lane used by test push and pop |
| tst_push | input | 1 | Test push strobe |
| tst_pop | input | 1 | Test pop strobe |
| tst_byte | input | 8 | Byte written by a test push |
| tst_par | input | 1 | Parity bit written by a test push |
| tst_rd_byte | output | 8 | Byte from the last test pop |
| tst_rd_par | output | 1 | Parity of the last test-popped byte |
| empty_mask | output | 4 | Per-lane empty flags |
| full_mask | output | 4 | Per-lane full flags |
| fifo_empty | output | 1 | All lanes empty |
| overflow | output | 1 | Sticky: a test push hit a full lane |

## Verification
Several properties are checked on every cycle. Each lane's fill count stays within bounds. A push against a full lane, or a pop against an empty lane, leaves the count as it was. The overflow flag stays set until a soft reset, and a soft reset empties all lanes. An accepted word leaves every lane non-empty, and `out_valid` is never high while the FIFO reports empty.

Other behaviour can only be shown by the bench's scenarios. These include data and parity ordering within a lane, and that a test push stores the parity bit it was given rather than a computed one. They also include the value captured by a pop from an empty lane, the exact fill level at which a full flag rises, and byte-to-lane placement on the word path with its generated parity.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;

  localparam int unsigned BYTE_W = 8;

  // one stored lane entry: parity bit above the data byte
  typedef struct packed {
    logic              par;
    logic [BYTE_W-1:0] data;
  } entry_t;

  // odd parity: the byte plus this bit carry an odd number of ones
  function automatic logic odd_par(input logic [BYTE_W-1:0] b);
    return ~^b;
  endfunction

endpackage

// File: rtl/dfifo_lane.sv
module dfifo_lane
  import dfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   push,
  input  logic   pop,
  input  entry_t din,
  output entry_t head,
  output logic   empty,
  output logic   full
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  entry_t        mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R6
  push_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (full && count == $past(count)));

  // R7
  pop_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !clr) |=> empty);

endmodule

// File: rtl/dfifo_steer.sv
module dfifo_steer
  import dfifo_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned SELW  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      soft_rst,
  input  logic                      in_valid,
  input  logic [LANES*BYTE_W-1:0]   in_data,
  output logic                      in_ready,
  input  logic                      out_ready,
  output logic                      out_valid,
  output logic [LANES*BYTE_W-1:0]   out_data,
  output logic [LANES-1:0]          out_par,
  input  logic [SELW-1:0]           tst_lane,
  input  logic                      tst_push,
  input  logic                      tst_pop,
  input  logic [BYTE_W-1:0]         tst_byte,
  input  logic                      tst_par,
  output logic [BYTE_W-1:0]         tst_rd_byte,
  output logic                      tst_rd_par,
  output logic                      overflow,
  input  logic [LANES-1:0]          lane_empty,
  input  logic [LANES-1:0]          lane_full,
  input  entry_t [LANES-1:0]        lane_head,
  output logic [LANES-1:0]          lane_push,
  output logic [LANES-1:0]          lane_pop,
  output entry_t [LANES-1:0]        lane_din
);

  logic tst_busy, wr_word, rd_word;

  assign tst_busy  = tst_push || tst_pop || soft_rst;
  assign in_ready  = !(|lane_full) && !tst_busy;
  assign out_valid = !(|lane_empty) && !tst_busy;
  assign wr_word   = in_valid && in_ready;
  assign rd_word   = out_valid && out_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] wbyte;
    logic              sel;
    assign sel          = (tst_lane == SELW'(g));
    assign wbyte        = in_data[g*BYTE_W +: BYTE_W];
    assign lane_push[g] = !soft_rst && (wr_word || (tst_push && sel));
    assign lane_pop[g]  = !soft_rst && (rd_word || (tst_pop && sel));
    assign lane_din[g]  = wr_word ? '{par: odd_par(wbyte), data: wbyte}
                                  : '{par: tst_par, data: tst_byte};
    assign out_data[g*BYTE_W +: BYTE_W] = lane_head[g].data;
    assign out_par[g]   = lane_head[g].par;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overflow    <= 1'b0;
      tst_rd_byte <= '0;
      tst_rd_par  <= 1'b0;
    end else if (soft_rst) begin
      overflow    <= 1'b0;
      tst_rd_byte <= '0;
      tst_rd_par  <= 1'b0;
    end else begin
      if (tst_push && lane_full[tst_lane]) overflow <= 1'b1;
      if (tst_pop) begin
        if (lane_empty[tst_lane]) begin
          tst_rd_byte <= '0;
          tst_rd_par  <= 1'b0;
        end else begin
          tst_rd_byte <= lane_head[tst_lane].data;
          tst_rd_par  <= lane_head[tst_lane].par;
        end
      end
    end
  end

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !soft_rst) |=> overflow);

endmodule

// File: rtl/lane_dma_fifo.sv
module lane_dma_fifo
  import dfifo_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned SELW  = $clog2(LANES),
  localparam int unsigned WORDW = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORDW-1:0]  in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORDW-1:0]  out_data,
  output logic [LANES-1:0]  out_par,
  input  logic [SELW-1:0]   tst_lane,
  input  logic              tst_push,
  input  logic              tst_pop,
  input  logic [BYTE_W-1:0] tst_byte,
  input  logic              tst_par,
  output logic [BYTE_W-1:0] tst_rd_byte,
  output logic              tst_rd_par,
  output logic [LANES-1:0]  empty_mask,
  output logic [LANES-1:0]  full_mask,
  output logic              fifo_empty,
  output logic              overflow
);

  logic   [LANES-1:0] lane_push, lane_pop;
  entry_t [LANES-1:0] lane_din, lane_head;

  for (genvar g = 0; g < LANES; g++) begin : g_store
    dfifo_lane #(.DEPTH(DEPTH)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_rst),
      .push  (lane_push[g]),
      .pop   (lane_pop[g]),
      .din   (lane_din[g]),
      .head  (lane_head[g]),
      .empty (empty_mask[g]),
      .full  (full_mask[g])
    );
  end

  dfifo_steer #(.LANES(LANES), .SELW(SELW)) u_steer (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ready    (in_ready),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_par     (out_par),
    .tst_lane    (tst_lane),
    .tst_push    (tst_push),
    .tst_pop     (tst_pop),
    .tst_byte    (tst_byte),
    .tst_par     (tst_par),
    .tst_rd_byte (tst_rd_byte),
    .tst_rd_par  (tst_rd_par),
    .overflow    (overflow),
    .lane_empty  (empty_mask),
    .lane_full   (full_mask),
    .lane_head   (lane_head),
    .lane_push   (lane_push),
    .lane_pop    (lane_pop),
    .lane_din    (lane_din)
  );

  // R10 status is derived from lane fill state
  assign fifo_empty = &empty_mask;

  // R11
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (empty_mask == '1 && !overflow));

  // R8
  word_push_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (empty_mask == '0));

  // R9
  out_valid_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !fifo_empty);

endmodule

// File: tb/lane_dma_fifo_bench.sv
module lane_dma_fifo_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic [3:0]  out_par;
  logic [1:0]  tst_lane = '0;
  logic        tst_push = 1'b0;
  logic        tst_pop = 1'b0;
  logic [7:0]  tst_byte = '0;
  logic        tst_par = 1'b0;
  logic [7:0]  tst_rd_byte;
  logic        tst_rd_par;
  logic [3:0]  empty_mask, full_mask;
  logic        fifo_empty, overflow;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  lane_dma_fifo u_lane_dma_fifo (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_par(out_par),
    .tst_lane(tst_lane), .tst_push(tst_push), .tst_pop(tst_pop),
    .tst_byte(tst_byte), .tst_par(tst_par),
    .tst_rd_byte(tst_rd_byte), .tst_rd_par(tst_rd_par),
    .empty_mask(empty_mask), .full_mask(full_mask),
    .fifo_empty(fifo_empty), .overflow(overflow)
  );

  // {pop, lane[1:0], par, data[7:0], exp_byte[7:0], exp_par, exp_empty[3:0]}
  localparam int NV = 11;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b1, 8'hA5, 8'h00, 1'b0, 4'b1110},
    {1'b0, 2'd2, 1'b0, 8'h3C, 8'h00, 1'b0, 4'b1010},
    {1'b0, 2'd0, 1'b0, 8'h5A, 8'h00, 1'b0, 4'b1010},
    {1'b1, 2'd0, 1'b0, 8'h00, 8'hA5, 1'b1, 4'b1010},
    {1'b1, 2'd0, 1'b0, 8'h00, 8'h5A, 1'b0, 4'b1011},
    {1'b1, 2'd2, 1'b0, 8'h00, 8'h3C, 1'b0, 4'b1111},
    {1'b1, 2'd1, 1'b0, 8'h00, 8'h00, 1'b0, 4'b1111},
    {1'b0, 2'd3, 1'b1, 8'hFF, 8'h00, 1'b0, 4'b0111},
    {1'b0, 2'd1, 1'b1, 8'h01, 8'h00, 1'b0, 4'b0101},
    {1'b1, 2'd3, 1'b0, 8'h00, 8'hFF, 1'b1, 4'b1101},
    {1'b1, 2'd1, 1'b0, 8'h00, 8'h01, 1'b1, 4'b1111}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] wpar(input logic [31:0] w);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ~^w[8*i +: 8];
    return p;
  endfunction

  function automatic logic [31:0] wval(input int i);
    return (32'h0101_0101 * i) ^ 32'hC3A5_5A3C;
  endfunction

  task automatic tpush(input logic [1:0] l, input logic p, input logic [7:0] b);
    @(negedge clk);
    tst_lane = l; tst_par = p; tst_byte = b; tst_push = 1'b1;
    @(negedge clk);
    tst_push = 1'b0;
  endtask

  task automatic tpop(input logic [1:0] l);
    @(negedge clk);
    tst_lane = l; tst_pop = 1'b1;
    @(negedge clk);
    tst_pop = 1'b0;
  endtask

  task automatic wpush(input logic [31:0] w);
    @(negedge clk);
    in_data = w; in_valid = 1'b1;
    #1 chk("R8 in_ready", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wpop(input logic [31:0] w);
    @(negedge clk);
    chk("R9 out_valid", {31'd0, out_valid}, 32'd1);
    chk("R9 out_data", out_data, w);
    chk("R9 R8 out_par", {28'd0, out_par}, {28'd0, wpar(w)});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty_mask", {28'd0, empty_mask}, 32'hF);
    chk("R1 full_mask", {28'd0, full_mask}, 32'h0);
    chk("R1 fifo_empty", {31'd0, fifo_empty}, 32'd1);
    chk("R1 overflow", {31'd0, overflow}, 32'd0);
    chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 tst_rd", {23'd0, tst_rd_par, tst_rd_byte}, 32'd0);

    // R2 R3 R4 R7 vector walk
    for (int v = 0; v < NV; v++) begin
      logic [24:0] e;
      e = VEC[v];
      if (e[24]) begin
        tpop(e[23:22]);
        chk("R3 R7 tst_rd_byte", {24'd0, tst_rd_byte}, {24'd0, e[12:5]});
        chk("R2 R3 tst_rd_par", {31'd0, tst_rd_par}, {31'd0, e[4]});
      end else begin
        tpush(e[23:22], e[21], e[20:13]);
      end
      chk("R4 empty_mask", {28'd0, empty_mask}, {28'd0, e[3:0]});
    end

    // R5 R6 fill lane 1
    for (int i = 0; i < 16; i++) begin
      tpush(2'd1, i[0], 8'h10 + 8'(i));
      if (i == 14) chk("R5 full below depth", {28'd0, full_mask}, 32'h0);
      if (i == 0) chk("R10 fifo_empty", {31'd0, fifo_empty}, 32'd0);
    end
    chk("R5 full at depth", {28'd0, full_mask}, 32'h2);
    tpush(2'd1, 1'b0, 8'hEE);
    chk("R6 overflow set", {31'd0, overflow}, 32'd1);
    chk("R6 full kept", {28'd0, full_mask}, 32'h2);
    for (int i = 0; i < 16; i++) begin
      tpop(2'd1);
      chk("R6 R3 order byte", {24'd0, tst_rd_byte}, 32'h10 + i);
      chk("R2 order par", {31'd0, tst_rd_par}, {31'd0, i[0]});
    end
    chk("R6 lane drained", {28'd0, empty_mask}, 32'hF);
    chk("R6 overflow sticky", {31'd0, overflow}, 32'd1);

    // R11 soft reset
    tpush(2'd0, 1'b1, 8'h77);
    @(negedge clk);
    soft_rst = 1'b1;
    tst_lane = 2'd2; tst_push = 1'b1; tst_byte = 8'h99;
    @(negedge clk);
    soft_rst = 1'b0; tst_push = 1'b0;
    chk("R11 empty_mask", {28'd0, empty_mask}, 32'hF);
    chk("R11 overflow", {31'd0, overflow}, 32'd0);
    chk("R11 tst_rd", {23'd0, tst_rd_par, tst_rd_byte}, 32'd0);
    chk("R11 fifo_empty", {31'd0, fifo_empty}, 32'd1);

    // R8 test strobe blocks word input
    @(negedge clk);
    tst_lane = 2'd2; tst_pop = 1'b1;
    #1 chk("R8 in_ready blocked", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    tst_pop = 1'b0;

    // R8 R9 word path
    wpush(32'h8001_7F03);
    wpush(32'hA5A5_0000);
    chk("R8 lanes filled", {28'd0, empty_mask}, 32'h0);
    wpop(32'h8001_7F03);
    wpop(32'hA5A5_0000);
    chk("R9 drained", {28'd0, empty_mask}, 32'hF);
    tpush(2'd0, 1'b0, 8'h42);
    chk("R9 one lane only", {31'd0, out_valid}, 32'd0);
    tpop(2'd0);
    chk("R3 lane0 byte", {24'd0, tst_rd_byte}, 32'h42);

    // R8 R9 full word depth
    for (int i = 0; i < 16; i++) wpush(wval(i));
    @(negedge clk);
    chk("R8 in_ready full", {31'd0, in_ready}, 32'd0);
    chk("R5 all full", {28'd0, full_mask}, 32'hF);
    for (int i = 0; i < 16; i++) wpop(wval(i));
    chk("R10 fifo_empty end", {31'd0, fifo_empty}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule